// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo audio off a three-wire serial link and turns it into parallel samples. The three wires are a bit clock, a frame clock that marks the channel, and serial data sent most significant bit first. The block runs entirely on the bit clock and samples the frame clock and the data on each rising edge. It recovers one left word and one right word per frame and holds each in its own 18-bit register.

A two-bit format input chooses how words sit inside the frame. The choices are the standard inter-IC sound framing, left-aligned, right-aligned, and a DSP style in which a one-clock sync pulse is followed by back-to-back left and right words. A width input chooses 16-bit or 18-bit words, and 16-bit words are sign-extended to 18 bits. A 16-bit packed frame uses 32 bit clocks per stereo pair, so each word fills its half-frame exactly. That frame is accepted in both the aligned formats.

The output side is a stream with a valid strobe and no ready. A serial link cannot be paused, so the receiver applies no back-pressure. Each valid strobe lasts one cycle, and the consumer must take the word in that cycle. The word then stays in its register until the next word of the same channel replaces it.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, both sample registers read zero and both valid strobes are low.
- R2: Format code 0 is inter-IC sound framing. A frame clock that is high marks the left slot and a low one marks the right slot. The MSB is the second sample taken after the frame clock changes level.
- R3: Format code 1 is left-aligned framing, with the same channel polarity as R2. The MSB is the first sample that shows the frame clock at its new level.
- R4: Format code 2 is right-aligned framing. The LSB is the last sample taken before the frame clock changes level, and the word is the selected number of bits ending there. A 1-to-0 change of the frame clock completes a left word, and a 0-to-1 change completes a right word.
- R5: Format code 3 is DSP framing. A frame starts at a sample where the frame clock is high after being low. The left MSB is the next sample, and the right word starts on the sample right after the left LSB. A falling frame clock has no effect.
- R6: When the width input is 1 the words are 18 bits wide. When it is 0 they are 16 bits wide, and bit 15 is copied into bits 17 and 16 of the register.
- R7: A 16-bit packed frame is received correctly in formats 1 and 2. In this frame each half holds exactly 16 samples, so the MSB follows one frame clock change and the LSB comes just before the next.
- R8: Slot bits outside the word's position have no effect on the received value. These are the bits after the word in formats 0, 1 and 3, and the bits before it in format 2.
- R9: The register and its valid strobe update on the clock edge that samples the word's last bit. In format 2 this is the edge that first sees the new frame clock level. The strobe is high for exactly that cycle. The two strobes are never high together, and a register does not change unless its strobe is high.
- R10: No word is delivered from the samples taken before the first frame start after reset. That first frame start is a frame clock change, or a rising frame clock in format 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing format code (0 to 3, see R2 to R5) |
| wide18 | input | 1 | Word width: 1 for 18 bits, 0 for 16 bits |
| lrck | input | 1 | Frame clock / channel marker |
| sdata | input | 1 | Serial data, MSB first |
| left_sample | output | 18 | Last received left word, sign-extended |
| left_valid | output | 1 | One-cycle strobe: a new left word was loaded |
| right_sample | output | 18 | Last received right word, sign-extended |
| right_valid | output | 1 | One-cycle strobe: a new right word was loaded |

## Verification
The bench sweeps all four formats at both widths. It uses slots that hold the word exactly (the packed case) and slots padded with pseudo-random filler, and the sample values include the extreme positive and negative codes and alternating bit patterns. If the design counted word positions one clock off, in the standard or left-aligned format, every word would come out shifted by one bit with filler or the neighbouring channel's LSB in it. A right-aligned receiver that counted forward instead of back from the frame clock change would take in the padding bits, and a DSP receiver that restarted on the falling frame clock would lose the right word. Each strobe is also checked against the exact sample index at which the last bit was taken. This catches an extra pipeline stage, an inverted channel marker, a missing sign extension, and a word invented from the partial slot before the first frame start.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } frame_fmt_e;

endpackage

// File: rtl/slot_timer.sv
// Tracks the frame clock: edge detection, frame start and bit position.
module slot_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck,
  input  logic             dsp_mode,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] run_len,
  output logic             lr_change,
  output logic             synced,
  output logic             lr_prev
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             primed_q;
  logic             lr_q;
  logic             synced_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign lr_change = primed_q && (lrck != lr_q);
  // DSP framing restarts only on a rising frame clock (the sync pulse).
  assign start     = dsp_mode ? (lr_change && lrck) : lr_change;
  assign pos       = start ? '0 : cnt_q;
  assign run_len   = cnt_q;
  assign synced    = synced_q;
  assign lr_prev   = lr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      lr_q     <= 1'b0;
      synced_q <= 1'b0;
      cnt_q    <= CNT_MAX;
    end else begin
      primed_q <= 1'b1;
      lr_q     <= lrck;
      synced_q <= synced_q | start;
      cnt_q    <= (pos == CNT_MAX) ? pos : pos + 1'b1;
    end
  end
endmodule

// File: rtl/bit_shifter.sv
// Serial-in history of the data line.
module bit_shifter #(
  parameter int MAX_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata,
  output logic [MAX_W-1:0] hist,
  output logic [MAX_W-1:0] hist_now
);
  logic [MAX_W-1:0] sh_q;

  assign hist     = sh_q;
  assign hist_now = {sh_q[MAX_W-2:0], sdata};

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= hist_now;
  end
endmodule

// File: rtl/sample_framer.sv
// Decides when a word is complete, which channel it is, and extends it.
module sample_framer
  import serial_audio_rx_pkg::*;
#(
  parameter int MAX_W = 18,
  parameter int MIN_W = 16,
  parameter int CNT_W = 6
) (
  input  logic [1:0]       fmt,
  input  logic             wide,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] run_len,
  input  logic             lr_change,
  input  logic             synced,
  input  logic             lrck,
  input  logic             lr_prev,
  input  logic [MAX_W-1:0] hist,
  input  logic [MAX_W-1:0] hist_now,
  output logic             done,
  output logic             is_left,
  output logic [MAX_W-1:0] word
);
  logic [CNT_W-1:0] w_sel;
  logic [MAX_W-1:0] src;

  assign w_sel = wide ? CNT_W'(MAX_W) : CNT_W'(MIN_W);

  always_comb begin
    done    = 1'b0;
    is_left = lrck;
    src     = hist_now;
    unique case (frame_fmt_e'(fmt))
      FMT_I2S: done = (pos == w_sel);
      FMT_LJ:  done = (pos == w_sel - 1'b1);
      FMT_RJ: begin
        // Word ended on the previous sample; count back from the edge.
        done    = lr_change && synced && (run_len >= w_sel);
        is_left = lr_prev;
        src     = hist;
      end
      FMT_DSP: begin
        is_left = (pos == w_sel);
        done    = (pos == w_sel) || (pos == (w_sel << 1));
      end
      default: done = 1'b0;
    endcase
  end

  for (genvar i = 0; i < MAX_W; i++) begin : g_ext
    if (i < MIN_W) begin : g_keep
      assign word[i] = src[i];
    end else begin : g_sign
      assign word[i] = wide ? src[i] : src[MIN_W-1];
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int MAX_W = 18,
  parameter int MIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_sel,
  input  logic             wide18,
  input  logic             lrck,
  input  logic             sdata,
  output logic [MAX_W-1:0] left_sample,
  output logic             left_valid,
  output logic [MAX_W-1:0] right_sample,
  output logic             right_valid
);
  import serial_audio_rx_pkg::*;

  localparam int CNT_W = $clog2(2 * MAX_W + 2);

  logic [CNT_W-1:0] pos, run_len;
  logic             lr_change, synced, lr_prev;
  logic [MAX_W-1:0] hist, hist_now, word;
  logic             done, is_left;

  slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .lrck     (lrck),
    .dsp_mode (fmt_sel == FMT_DSP),
    .pos      (pos),
    .run_len  (run_len),
    .lr_change(lr_change),
    .synced   (synced),
    .lr_prev  (lr_prev)
  );

  bit_shifter #(.MAX_W(MAX_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdata   (sdata),
    .hist    (hist),
    .hist_now(hist_now)
  );

  sample_framer #(.MAX_W(MAX_W), .MIN_W(MIN_W), .CNT_W(CNT_W)) u_framer (
    .fmt      (fmt_sel),
    .wide     (wide18),
    .pos      (pos),
    .run_len  (run_len),
    .lr_change(lr_change),
    .synced   (synced),
    .lrck     (lrck),
    .lr_prev  (lr_prev),
    .hist     (hist),
    .hist_now (hist_now),
    .done     (done),
    .is_left  (is_left),
    .word     (word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_sample  <= '0;
      right_sample <= '0;
      left_valid   <= 1'b0;
      right_valid  <= 1'b0;
    end else begin
      left_valid  <= done && is_left;
      right_valid <= done && !is_left;
      if (done && is_left)  left_sample  <= word;
      if (done && !is_left) right_sample <= word;
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk
  import serial_audio_rx_pkg::*;
#(
  parameter int MAX_W = 18,
  parameter int MIN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       fmt_sel,
  input logic             wide18,
  input logic             lrck,
  input logic [MAX_W-1:0] left_sample,
  input logic             left_valid,
  input logic [MAX_W-1:0] right_sample,
  input logic             right_valid
);
  logic primed_q, prev_q, seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      prev_q   <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      prev_q   <= lrck;
      seen_q   <= seen_q | (primed_q && (lrck != prev_q));
    end
  end

  // R9: never both strobes at once
  a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({left_valid, right_valid}));

  // R10: nothing before the first frame clock change
  a_r10_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid) |-> seen_q);

  // R3: left-aligned left words come from a high frame clock
  a_r3_lj_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid && $past(fmt_sel) == FMT_LJ) |-> $past(lrck));

  // R4: right-aligned words close on the matching frame clock change
  a_r4_rj_left_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid && $past(fmt_sel) == FMT_RJ) |-> ($past(lrck, 2) && !$past(lrck)));
  a_r4_rj_right_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (right_valid && $past(fmt_sel) == FMT_RJ) |-> (!$past(lrck, 2) && $past(lrck)));

  // R6: 16-bit words are sign-extended
  a_r6_left_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid && !$past(wide18)) |->
      ((&left_sample[MAX_W-1:MIN_W-1]) || !(|left_sample[MAX_W-1:MIN_W-1])));
  a_r6_right_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (right_valid && !$past(wide18)) |->
      ((&right_sample[MAX_W-1:MIN_W-1]) || !(|right_sample[MAX_W-1:MIN_W-1])));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fmt_sel     (fmt_sel),
  .wide18      (wide18),
  .lrck        (lrck),
  .left_sample (left_sample),
  .left_valid  (left_valid),
  .right_sample(right_sample),
  .right_valid (right_valid)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        wide18 = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [17:0] left_sample, right_sample;
  logic        left_valid, right_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wide18(wide18),
    .lrck(lrck), .sdata(sdata),
    .left_sample(left_sample), .left_valid(left_valid),
    .right_sample(right_sample), .right_valid(right_valid)
  );

  int tests = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  bit lr_s [0:4095];
  bit sd_s [0:4095];
  int n;

  int          ex_n, ob_n;
  bit          ex_left [0:15];
  logic [17:0] ex_data [0:15];
  int          ex_idx  [0:15];
  bit          ob_left [0:15];
  logic [17:0] ob_data [0:15];
  int          ob_idx  [0:15];

  function automatic bit nextj();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  function automatic logic [17:0] sx(input logic [17:0] v, input int w);
    if (w == 16) return {{2{v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit l, input bit d);
    lr_s[n] = l; sd_s[n] = d; n++;
  endtask

  task automatic add_exp(input bit left, input logic [17:0] v, input int w, input int idx);
    ex_left[ex_n] = left; ex_data[ex_n] = sx(v, w); ex_idx[ex_n] = idx; ex_n++;
  endtask

  task automatic add_pair(input int f, input int w, input int s,
                          input logic [17:0] lv, input logic [17:0] rv);
    int fs;
    logic [17:0] wd;
    bit d;
    fs = n;
    if (f == 3) begin
      for (int p = 0; p < 2*s; p++) begin
        if (p >= 1 && p <= w)            d = lv[w-p];
        else if (p > w && p <= 2*w)      d = rv[2*w-p];
        else                             d = nextj();
        push(p == 0, d);
      end
      add_exp(1'b1, lv, w, fs + w);
      add_exp(1'b0, rv, w, fs + 2*w);
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        wd = (ch == 0) ? lv : rv;
        for (int p = 0; p < s; p++) begin
          if (f == 0)      d = (p >= 1 && p <= w) ? wd[w-p] : nextj();
          else if (f == 1) d = (p < w) ? wd[w-1-p] : nextj();
          else             d = (p >= s - w) ? wd[s-1-p] : nextj();
          push(ch == 0, d);
        end
      end
      if (f == 0)      begin add_exp(1'b1, lv, w, fs + w);     add_exp(1'b0, rv, w, fs + s + w);     end
      else if (f == 1) begin add_exp(1'b1, lv, w, fs + w - 1); add_exp(1'b0, rv, w, fs + s + w - 1); end
      else             begin add_exp(1'b1, lv, w, fs + s);     add_exp(1'b0, rv, w, fs + 2*s);       end
    end
  endtask

  task automatic run_cfg(input int f, input bit wd, input int s);
    int w;
    logic [17:0] mask, lv, rv, last_l, last_r;
    bit hold_bad, both_bad;
    string ftag, stag, tags;
    w = wd ? 18 : 16;
    mask = (18'h1 << w) - 18'h1;
    ftag = (f == 0) ? "R2" : (f == 1) ? "R3" : (f == 2) ? "R4" : "R5";
    stag = (s == w) ? "R7" : "R8";
    tags = $sformatf("%s/R6/%s fmt=%0d w=%0d slot=%0d", ftag, stag, f, w, s);
    n = 0; ex_n = 0; ob_n = 0;
    for (int p = 0; p < w + 3; p++) push(1'b0, nextj());   // preamble, R10
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: begin lv = (18'h1 << (w-1)) - 18'h1; rv = 18'h1 << (w-1); end
        1: begin lv = 18'h2AAAA & mask; rv = 18'h15555 & mask; end
        2: begin lv = mask; rv = 18'h1; end
        default: begin lv = {lfsr, lfsr[1:0]} & mask; rv = ~lv & mask; end
      endcase
      add_pair(f, w, s, lv, rv);
    end
    push(f != 3, nextj());
    push(f != 3, nextj());

    @(negedge clk);
    rst_n = 1'b0; fmt_sel = 2'(f); wide18 = wd; lrck = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    chk(left_sample == 18'd0 && right_sample == 18'd0 && !left_valid && !right_valid,
        "R1", "reset state", int'({left_valid, right_valid, left_sample ^ right_sample}), 0);
    rst_n = 1'b1; lrck = lr_s[0]; sdata = sd_s[0];
    last_l = '0; last_r = '0; hold_bad = 0; both_bad = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (left_valid && right_valid) both_bad = 1;
      if (left_valid) begin
        if (ob_n < 16) begin ob_left[ob_n] = 1; ob_data[ob_n] = left_sample; ob_idx[ob_n] = i - 1; end
        ob_n++; last_l = left_sample;
      end else if (left_sample != last_l) hold_bad = 1;
      if (right_valid) begin
        if (ob_n < 16) begin ob_left[ob_n] = 0; ob_data[ob_n] = right_sample; ob_idx[ob_n] = i - 1; end
        ob_n++; last_r = right_sample;
      end else if (right_sample != last_r) hold_bad = 1;
      if (i < n) begin lrck = lr_s[i]; sdata = sd_s[i]; end
    end

    chk(ob_n == ex_n, $sformatf("R10 %s", tags), "word count", ob_n, ex_n);
    chk(!both_bad && !hold_bad, "R9", "exclusive strobes / held registers",
        int'({both_bad, hold_bad}), 0);
    for (int k = 0; k < ex_n && k < ob_n && k < 16; k++) begin
      chk(ob_left[k] == ex_left[k] && ob_data[k] == ex_data[k], tags,
          $sformatf("word %0d (chan/data)", k),
          int'({ob_left[k], ob_data[k]}), int'({ex_left[k], ex_data[k]}));
      chk(ob_idx[k] == ex_idx[k], $sformatf("R9 %s", tags),
          $sformatf("word %0d strobe sample index", k), ob_idx[k], ex_idx[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R1..R10 run incomplete): actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int f = 0; f < 4; f++) begin
      for (int wdi = 0; wdi < 2; wdi++) begin
        int w, s0;
        w  = (wdi != 0) ? 18 : 16;
        s0 = (f == 1 || f == 2) ? w : w + 1;
        run_cfg(f, wdi != 0, s0);
        run_cfg(f, wdi != 0, 24);
        run_cfg(f, wdi != 0, 32);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule